// File: doc/BRIEF.md
# Zero-Current Detect Cycle Trigger

This block decides when a critical-conduction-mode switching converter may begin its next switching cycle. An auxiliary winding carries a copy of the inductor voltage. Two comparators outside the block turn that voltage into two digital levels: one says the winding is above a high "arm" level and the other says it is above a lower "trigger" level. A high swing of the winding arms a latch. The next fall below the trigger level means the inductor current has reached zero, and the block then issues a one-clock start pulse to the gate-drive logic.

The block also has to start the converter when no winding signal exists yet, for example at power-up. For that it has a restart watchdog. If the gate drive has stayed off for longer than a timeout, which is a parameter counted in clock cycles, the watchdog issues a start pulse. An active overvoltage or undervoltage fault holds the watchdog idle. The drive-on input clears the arm latch, so ringing during the on time cannot produce a false zero-current event.

All pins are plain control levels. No data flows through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `zcd_cycle_trigger`

## Requirements
- R1: The detector arms only after the synchronized `zc_above_arm` input has been seen high while the drive is off. Once armed, it stays armed after `zc_above_arm` falls again, so an arm pulse of only a few clocks is still honoured. A fall of `zc_above_trig` with no prior arm produces no start pulse.
- R2: When the detector is armed and the synchronized `zc_above_trig` input is low, `start_pulse` is driven high. Counted from the clock edge that first samples `zc_above_trig` low, `start_pulse` is high after the third edge.
- R3: While `drive_on` is high, the arm latch is held clear, and the clear wins over a simultaneous arm. An arm level seen only during the on time arms nothing. Turning the drive on while the detector is armed discards the armed state.
- R4: `zc_above_arm` and `zc_above_trig` each pass through a two-flop synchronizer before any use.
- R5: The watchdog starts counting when the drive turns off. After `TIMEOUT_CYC`+1 consecutive clock edges that sample `drive_on` low with no fault active, `start_pulse` goes high. If the drive stays off, further watchdog pulses follow every `TIMEOUT_CYC`+1 edges.
- R6: While `fault_ovp` or `fault_uvp` is high, the watchdog count is held at zero and no watchdog pulse is issued. When the fault releases, a full timeout is counted from the release.
- R7: `start_pulse` is never high for two consecutive cycles. Each start pulse, whether it comes from a zero-current event or from the watchdog, clears both the arm latch and the watchdog count.
- R8: Any cycle that samples `drive_on` high clears the watchdog count.
- R9: During and right after reset, `start_pulse` is low, the detector is unarmed and the watchdog count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| zc_above_arm | input | 1 | Asynchronous comparator: winding sense is above the arm level |
| zc_above_trig | input | 1 | Asynchronous comparator: winding sense is above the trigger level |
| drive_on | input | 1 | Present gate-drive state, high while the switch is on |
| fault_ovp | input | 1 | Overvoltage fault active (synchronous) |
| fault_uvp | input | 1 | Undervoltage fault active (synchronous) |
| start_pulse | output | 1 | One-clock request to begin the next switching cycle |

## Verification
The bench aims at the timing boundaries that separate a correct trigger from a broken one.

- **Watchdog count:** the watchdog pulse must land exactly `TIMEOUT_CYC`+1 cycles after the drive turns off, after a fault releases, after a one-cycle drive blip, and after a zero-current start. An off-by-one comparison, or a count not cleared by a start, shows up as a pulse one cycle off or a missing pulse.
- **Arm latch:** an arm pulse that ends well before the trigger fall must still fire the start. An arm level seen only during the on time must not fire it. A detector armed and then interrupted by a drive-on must not fire it. A design that samples the arm level instead of latching it, or lets the arm set win over the drive-on clear, would produce a missing or a spurious pulse.
- **Faults and pulse shape:** a fault must hold the watchdog silent for several timeouts. A start must be exactly one cycle wide, or the scoreboard sees an unexpected pulse.

// File: rtl/zcd_trig_pkg.sv
package zcd_trig_pkg;
  // Digitized comparator levels from the auxiliary winding sense.
  typedef struct packed {
    logic above_arm;
    logic above_trig;
  } zcd_cmp_t;

  localparam int unsigned CMP_W = $bits(zcd_cmp_t);
endpackage

// File: rtl/zcd_sync.sv
module zcd_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int unsigned TOP = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= {stage_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stage_q[TOP];
endmodule

// File: rtl/zcd_arm_latch.sv
module zcd_arm_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_lvl,
  input  logic trig_lvl,
  input  logic drive_on,
  input  logic clr_i,
  output logic zc_fire_o
);
  logic armed_q;

  // Reset-dominant set/reset latch: the drive-on or start clear wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (clr_i)    armed_q <= 1'b0;
    else if (arm_lvl)  armed_q <= 1'b1;
  end

  assign zc_fire_o = armed_q & ~trig_lvl & ~drive_on;

  // R3: a cycle with the drive on leaves the detector unarmed
  assert_clear_on_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drive_on |=> !armed_q);

  // R1: arming follows a sampled arm level
  assert_arm_from_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(arm_lvl));
endmodule

// File: rtl/zcd_restart_timer.sv
module zcd_restart_timer #(
  parameter int unsigned TIMEOUT_CYC = 18000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic drive_on,
  input  logic fault,
  input  logic restart_i,
  output logic kick_o
);
  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);

  logic [CW-1:0] cnt_q;

  assign kick_o = ~drive_on & ~fault & (cnt_q == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           cnt_q <= '0;
    else if (drive_on | fault | restart_i) cnt_q <= '0;
    else                                   cnt_q <= cnt_q + 1'b1;
  end

  // R5: the count never runs past the timeout
  assert_no_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);

  // R6 / R8: a nonzero count means the previous cycle was drive-off and fault-free
  assert_count_needs_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> $past(!drive_on && !fault));
endmodule

// File: rtl/zcd_cycle_trigger.sv
module zcd_cycle_trigger #(
  parameter int unsigned TIMEOUT_CYC = 18000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic zc_above_arm,
  input  logic zc_above_trig,
  input  logic drive_on,
  input  logic fault_ovp,
  input  logic fault_uvp,
  output logic start_pulse
);
  import zcd_trig_pkg::*;

  zcd_cmp_t cmp_raw, cmp_s;
  logic     zc_fire, kick, start_now, start_q;

  assign cmp_raw.above_arm  = zc_above_arm;
  assign cmp_raw.above_trig = zc_above_trig;

  zcd_sync #(.WIDTH(CMP_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (cmp_raw),
    .q_o   (cmp_s)
  );

  zcd_arm_latch u_arm (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_lvl   (cmp_s.above_arm),
    .trig_lvl  (cmp_s.above_trig),
    .drive_on  (drive_on),
    .clr_i     (drive_on | start_now),
    .zc_fire_o (zc_fire)
  );

  zcd_restart_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .drive_on  (drive_on),
    .fault     (fault_ovp | fault_uvp),
    .restart_i (start_now),
    .kick_o    (kick)
  );

  assign start_now = zc_fire | kick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= start_now;
  end

  assign start_pulse = start_q;

  // R7: a start request lasts a single cycle
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);
endmodule

// File: tb/zcd_cycle_trigger_bench.sv
module zcd_cycle_trigger_bench;
  localparam int unsigned T = 40;

  logic clk = 1'b0;
  logic rst_n, arm, trig, drv, ovp, uvp, start;

  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  int seen = 0;
  int expq[$];
  bit finished = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  zcd_cycle_trigger #(.TIMEOUT_CYC(T)) u_zcd_cycle_trigger (
    .clk(clk), .rst_n(rst_n), .zc_above_arm(arm), .zc_above_trig(trig),
    .drive_on(drv), .fault_ovp(ovp), .fault_uvp(uvp), .start_pulse(start)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_cyc(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic push_exp(input int c);
    expq.push_back(c);
  endtask

  task automatic end_test(input int n_exp, input string tag);
    n_checks++;
    if (seen != n_exp) begin
      n_fail++;
      $display("FAIL %s: start pulses seen %0d, expected %0d", tag, seen, n_exp);
    end
    seen = 0;
  endtask

  // Scoreboard monitor: every pulse must match the front expected cycle.
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      while (expq.size() > 0 && expq[0] < cyc) begin
        n_checks++; n_fail++;
        $display("FAIL R2/R5: missed start pulse, actual none, expected cycle %0d", expq[0]);
        void'(expq.pop_front());
      end
      if (start === 1'b1) begin
        seen++;
        n_checks++;
        if (expq.size() == 0) begin
          n_fail++;
          $display("FAIL R1/R3/R7: unexpected start at cycle %0d, expected none", cyc);
        end else if (expq[0] != cyc) begin
          n_fail++;
          $display("FAIL R2/R5: start at cycle %0d, expected cycle %0d", cyc, expq[0]);
        end else begin
          void'(expq.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int c0, d;
    rst_n = 1'b0; arm = 1'b0; trig = 1'b0; drv = 1'b1; ovp = 1'b0; uvp = 1'b0;
    step(3);
    n_checks++;
    if (start !== 1'b0) begin n_fail++; $display("FAIL R9: start in reset %b, expected 0", start); end
    rst_n = 1'b1;
    step(3);
    n_checks++;
    if (start !== 1'b0) begin n_fail++; $display("FAIL R9: start after reset %b, expected 0", start); end

    // R2 R4 R7: arm then trigger fall; the start also restarts the watchdog
    drv = 1'b0;
    step(3); arm = 1'b1; trig = 1'b1;
    step(5); arm = 1'b0;
    step(3); d = cyc; trig = 1'b0;
    push_exp(d + 3);
    push_exp(d + 3 + T + 1);
    wait_cyc(d + 3 + T + 1);
    drv = 1'b1; step(3);
    end_test(2, "R2_R7");

    // R1: trigger fall with no arm gives nothing
    drv = 1'b0; trig = 1'b1;
    step(6); trig = 1'b0;
    step(8); drv = 1'b1; step(3);
    end_test(0, "R1");

    // R1: short arm pulse is latched
    drv = 1'b0; trig = 1'b1; arm = 1'b1;
    step(7); arm = 1'b0;
    step(10); d = cyc; trig = 1'b0;
    push_exp(d + 3);
    step(6); drv = 1'b1; step(3);
    end_test(1, "R1");

    // R3: arm level only during the on time
    trig = 1'b1; arm = 1'b1;
    step(5); arm = 1'b0;
    step(5); drv = 1'b0;
    step(4); trig = 1'b0;
    step(8); drv = 1'b1; step(3);
    end_test(0, "R3");

    // R3: armed, then drive on discards the armed state
    drv = 1'b0; trig = 1'b1; arm = 1'b1;
    step(4); arm = 1'b0;
    step(4); drv = 1'b1;
    step(1); drv = 1'b0;
    step(3); trig = 1'b0;
    step(8); drv = 1'b1; step(3);
    end_test(0, "R3");

    // R5: watchdog fires at exactly timeout+1 and repeats
    c0 = cyc; drv = 1'b0;
    push_exp(c0 + T + 1);
    push_exp(c0 + 2 * T + 2);
    wait_cyc(c0 + 2 * T + 2);
    drv = 1'b1; step(3);
    end_test(2, "R5");

    // R8: one-cycle drive blip restarts the count
    drv = 1'b0;
    step(20); drv = 1'b1;
    step(1); c0 = cyc; drv = 1'b0;
    push_exp(c0 + T + 1);
    wait_cyc(c0 + T + 1);
    drv = 1'b1; step(3);
    end_test(1, "R8");

    // R6: overvoltage fault holds the watchdog idle
    ovp = 1'b1; drv = 1'b0;
    step(3 * T); c0 = cyc; ovp = 1'b0;
    push_exp(c0 + T + 1);
    wait_cyc(c0 + T + 1);
    drv = 1'b1; step(3);
    end_test(1, "R6_ovp");

    // R6: undervoltage fault in mid-count
    drv = 1'b0;
    step(20); uvp = 1'b1;
    step(2 * T); c0 = cyc; uvp = 1'b0;
    push_exp(c0 + T + 1);
    wait_cyc(c0 + T + 1);
    drv = 1'b1; step(3);
    end_test(1, "R6_uvp");

    n_checks++;
    if (expq.size() != 0) begin
      n_fail++;
      $display("FAIL R5: %0d expected pulses left, expected 0", expq.size());
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule